// File: doc/BRIEF.md
# Compact 8-bit Instruction Executor

This block executes a narrow set of 16-bit instruction words against three stores. The first is a 32 x 8-bit register file. The second is an I/O register space of configurable depth. The third is a small data SRAM that is filled with a computed pattern at reset. Words arrive one at a time on a valid/ready port. Single-word operations take effect at the clock edge that accepts them. The absolute load is the only operation that needs two words and takes more cycles than that.

The block decodes several operand layouts that share the one 16-bit word:
- two 5-bit register fields, one of which is split across non-adjacent bits;
- an 8-bit constant stored as two separate nibbles;
- a 4-bit register field that only reaches the upper half of the register file;
- a 5-bit I/O index paired with a 3-bit bit position.

A zero flag, a carry flag and a sticky address-error bit are kept. A read port lets the surrounding logic, or a bench, observe any general register or I/O register.

Top module: `op8_exec`

## Requirements
- R1: After reset, all 32 general registers are 0x00 and every I/O register is 0xFF. Zero, carry and the error bit are 0, `instr_ready` is 1 and `busy` is 0. SRAM byte a holds (a*37+5) mod 256.
- R2: Word 1001010ddddd0001 replaces register d with its two's complement (0 - value, modulo 256).
- R3: Word 000011rdddddrrrr adds two registers and writes the 8-bit sum to d. The destination index d is bits 8:4. The source index r has its high bit at bit 9 and its low four bits at 3:0. Carry is set to the ninth bit of the sum.
- R4: Word 001000rdddddrrrr writes the bitwise AND of registers d and r to d. It uses the same field positions as R3.
- R5: Word 0111KKKKddddKKKK ANDs register 16+dddd with an 8-bit constant. Bits 11:8 form the upper nibble of the constant and bits 3:0 form the lower nibble.
- R6: Word 1001000ddddd0000 is followed by a second word holding a 16-bit data address. The SRAM byte at that address is written to register d in the cycle after the address word is accepted.
- R7: While waiting for the address word, `instr_ready` stays 1 and `busy` is 1. In the cycle after the address word is accepted, `instr_ready` is 0 and `busy` is 1. After that cycle the block is idle again.
- R8: Operations R2 to R5 set zero exactly when their result is 0x00. Only R3 writes carry. Loads, bit clears and unrecognised words change neither flag.
- R9: A load from an address at or above the SRAM depth (32) returns 0x00 and sets the error bit. The error bit then stays set until reset.
- R10: Word 10011000AAAAAbbb clears bit bbb of I/O register AAAAA, which ranges over 0 to 31. Every other bit and register is unchanged, including I/O registers 32 to 63.
- R11: Any other word is accepted in one cycle and has no effect. `busy` stays 0.
- R12: The word that follows a load opcode is used only as an address, even when its value would decode as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction or address word is present |
| instr_word | input | 16 | Instruction or address word |
| instr_ready | output | 1 | Block takes the word at this edge if valid |
| busy | output | 1 | A two-word load is in progress |
| rf_rd_idx | input | 5 | General register to observe |
| rf_rd_data | output | 8 | Contents of the observed general register |
| io_rd_idx | input | 6 | I/O register to observe |
| io_rd_data | output | 8 | Contents of the observed I/O register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| addr_err | output | 1 | Sticky out-of-range load indicator |

## Verification
The bench targets the following corner cases:
- **Split register field.** It uses source registers 17 and 31 to exercise the high bit of the source index. A decoder that read the source index from contiguous bits would add the wrong register.
- **Two-nibble constant.** It uses constants with distinct upper and lower nibbles, so swapping the two nibbles gives a wrong result.
- **Upper-half register field.** It targets registers 17 and 31, so a missing +16 offset would corrupt the lower half of the register file.
- **Carry from operations other than add.** It checks carry after AND, immediate AND and negate, where a design that wrote carry from these operations would lose a carry set by an earlier add.
- **Address word that looks like an opcode.** It sends an address word whose value decodes as a negate. Executing that word as an instruction would alter a register.
- **SRAM depth boundary.** It loads from the last SRAM address and the first address past it. The error bit must stay set across later in-range loads.
- **Unreachable I/O registers.** It checks that I/O registers beyond index 31 keep their reset value.

// File: rtl/op8_pkg.sv
package op8_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_NEG,
        OP_ADD,
        OP_AND,
        OP_ANDI,
        OP_LDS,
        OP_CBI
    } op_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LOAD
    } exec_state_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [4:0] rd;
        logic [4:0] rr;
        logic [7:0] imm;
        logic [4:0] io_idx;
        logic [2:0] bitpos;
    } dec_t;

endpackage

// File: rtl/op8_decode.sv
module op8_decode
    import op8_pkg::*;
(
    input  logic [15:0] word,
    output dec_t        dec
);
    always_comb begin
        dec.kind   = OP_NOP;
        dec.rd     = word[8:4];
        dec.rr     = {word[9], word[3:0]};
        dec.imm    = {word[11:8], word[3:0]};
        dec.io_idx = word[7:3];
        dec.bitpos = word[2:0];

        if (word[15:10] == 6'b000011) begin
            dec.kind = OP_ADD;
        end else if (word[15:10] == 6'b001000) begin
            dec.kind = OP_AND;
        end else if (word[15:12] == 4'b0111) begin
            dec.kind = OP_ANDI;
            dec.rd   = {1'b1, word[7:4]};
        end else if (word[15:9] == 7'b1001010 && word[3:0] == 4'b0001) begin
            dec.kind = OP_NEG;
        end else if (word[15:9] == 7'b1001000 && word[3:0] == 4'b0000) begin
            dec.kind = OP_LDS;
        end else if (word[15:8] == 8'b10011000) begin
            dec.kind = OP_CBI;
        end
    end
endmodule

// File: rtl/op8_alu.sv
module op8_alu
    import op8_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_kind_t        kind,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [DW-1:0]   imm,
    output logic [DW-1:0]   res,
    output logic            zero,
    output logic            carry,
    output logic            wr_en,
    output logic            wr_carry
);
    logic [DW:0] sum_w;

    always_comb begin
        sum_w    = {1'b0, opa} + {1'b0, opb};
        res      = '0;
        carry    = 1'b0;
        wr_en    = 1'b1;
        wr_carry = 1'b0;
        unique case (kind)
            OP_NEG:  res = (~opa) + DW'(1);
            OP_ADD: begin
                res      = sum_w[DW-1:0];
                carry    = sum_w[DW];
                wr_carry = 1'b1;
            end
            OP_AND:  res = opa & opb;
            OP_ANDI: res = opa & imm;
            default: wr_en = 1'b0;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/op8_sram.sv
module op8_sram #(
    parameter int DEPTH    = 32,
    parameter int SEED_MUL = 37,
    parameter int SEED_ADD = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] rd_addr,
    output logic [7:0]  rd_data,
    output logic        rd_oob
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'(i * SEED_MUL + SEED_ADD);
            end
        end
    end

    always_comb begin
        rd_oob  = (32'(rd_addr) >= DEPTH);
        rd_data = rd_oob ? 8'h00 : mem_q[rd_addr[AW-1:0]];
    end
endmodule

// File: rtl/op8_exec.sv
module op8_exec
    import op8_pkg::*;
#(
    parameter int SRAM_DEPTH = 32,
    parameter int IO_DEPTH   = 64,
    parameter int SEED_MUL   = 37,
    parameter int SEED_ADD   = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        instr_valid,
    input  logic [15:0] instr_word,
    output logic        instr_ready,
    output logic        busy,
    input  logic [4:0]  rf_rd_idx,
    output logic [7:0]  rf_rd_data,
    input  logic [$clog2(IO_DEPTH)-1:0] io_rd_idx,
    output logic [7:0]  io_rd_data,
    output logic        flag_z,
    output logic        flag_c,
    output logic        addr_err
);
    localparam int DW      = 8;
    localparam int RF_N    = 32;
    localparam int IO_AW   = $clog2(IO_DEPTH);

    typedef struct packed {
        exec_state_t                 st;
        logic [RF_N-1:0][DW-1:0]     rf;
        logic [IO_DEPTH-1:0][DW-1:0] io;
        logic                        z;
        logic                        c;
        logic                        err;
        logic [4:0]                  ld_rd;
        logic [15:0]                 ld_addr;
    } exec_regs_t;

    exec_regs_t q, d;
    dec_t       dec;
    logic       accept;
    logic [DW-1:0] alu_res;
    logic       alu_zero, alu_carry, alu_wr, alu_wc;
    logic [DW-1:0] mem_data;
    logic       mem_oob;

    op8_decode u_dec (
        .word (instr_word),
        .dec  (dec)
    );

    op8_alu #(.DW(DW)) u_alu (
        .kind     (dec.kind),
        .opa      (q.rf[dec.rd]),
        .opb      (q.rf[dec.rr]),
        .imm      (dec.imm),
        .res      (alu_res),
        .zero     (alu_zero),
        .carry    (alu_carry),
        .wr_en    (alu_wr),
        .wr_carry (alu_wc)
    );

    op8_sram #(
        .DEPTH    (SRAM_DEPTH),
        .SEED_MUL (SEED_MUL),
        .SEED_ADD (SEED_ADD)
    ) u_sram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (q.ld_addr),
        .rd_data (mem_data),
        .rd_oob  (mem_oob)
    );

    assign instr_ready = (q.st != ST_LOAD);
    assign busy        = (q.st != ST_IDLE);
    assign accept      = instr_valid && instr_ready;
    assign rf_rd_data  = q.rf[rf_rd_idx];
    assign io_rd_data  = q.io[io_rd_idx];
    assign flag_z      = q.z;
    assign flag_c      = q.c;
    assign addr_err    = q.err;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (alu_wr) begin
                        d.rf[dec.rd] = alu_res;
                        d.z          = alu_zero;
                        if (alu_wc) d.c = alu_carry;
                    end
                    if (dec.kind == OP_CBI) begin
                        d.io[IO_AW'(dec.io_idx)][dec.bitpos] = 1'b0;
                    end
                    if (dec.kind == OP_LDS) begin
                        d.ld_rd = dec.rd;
                        d.st    = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                if (accept) begin
                    d.ld_addr = instr_word;
                    d.st      = ST_LOAD;
                end
            end
            ST_LOAD: begin
                d.rf[q.ld_rd] = mem_data;
                if (mem_oob) d.err = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.rf      <= '0;
            q.io      <= '1;
            q.z       <= 1'b0;
            q.c       <= 1'b0;
            q.err     <= 1'b0;
            q.ld_rd   <= '0;
            q.ld_addr <= '0;
        end else begin
            q <= d;
        end
    end

    // R7: after a load opcode the port keeps taking a word, now as an address
    a_r7_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy && dec.kind == OP_LDS) |=> (busy && instr_ready));

    // R7: the cycle after the address word the port is closed
    a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && busy) |=> (busy && !instr_ready));

    // R9: the error bit never clears on its own
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |=> addr_err);

    // R8: carry moves only on an accepted add
    a_r8_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && !busy && dec.kind == OP_ADD) |=> $stable(flag_c));

    // R8: zero reflects the register just written by an arithmetic/logic word
    a_r8_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !busy && (dec.kind == OP_NEG || dec.kind == OP_ADD ||
                             dec.kind == OP_AND || dec.kind == OP_ANDI))
        |=> (flag_z == (q.rf[$past(dec.rd)] == 8'h00)));
endmodule

// File: tb/sim_op8_exec.sv
module sim_op8_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic        instr_ready, busy;
    logic [4:0]  rf_rd_idx = 5'd0;
    logic [7:0]  rf_rd_data;
    logic [5:0]  io_rd_idx = 6'd0;
    logic [7:0]  io_rd_data;
    logic        flag_z, flag_c, addr_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    op8_exec u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .instr_ready (instr_ready),
        .busy        (busy),
        .rf_rd_idx   (rf_rd_idx),
        .rf_rd_data  (rf_rd_data),
        .io_rd_idx   (io_rd_idx),
        .io_rd_data  (io_rd_data),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .addr_err    (addr_err)
    );

    typedef struct packed {
        logic [15:0] w0;
        logic [15:0] w1;
        logic [4:0]  rix;
        logic [7:0]  val;
        logic        z;
        logic        c;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{16'h9010, 16'h0001, 5'd1,  8'h2A, 1'b0, 1'b0},
        '{16'h9110, 16'h0004, 5'd17, 8'h99, 1'b0, 1'b0},
        '{16'h9020, 16'h0006, 5'd2,  8'hE3, 1'b0, 1'b0},
        '{16'h0C12, 16'h0000, 5'd1,  8'h0D, 1'b0, 1'b1},
        '{16'h0F11, 16'h0000, 5'd17, 8'h32, 1'b0, 1'b1},
        '{16'h2221, 16'h0000, 5'd2,  8'h22, 1'b0, 1'b1},
        '{16'h701D, 16'h0000, 5'd17, 8'h00, 1'b1, 1'b1},
        '{16'h9411, 16'h0000, 5'd1,  8'hF3, 1'b0, 1'b1},
        '{16'h0C31, 16'h0000, 5'd3,  8'hF3, 1'b0, 1'b0},
        '{16'h9441, 16'h0000, 5'd4,  8'h00, 1'b1, 1'b0},
        '{16'h91F0, 16'h0003, 5'd31, 8'h74, 1'b1, 1'b0},
        '{16'h7AF5, 16'h0000, 5'd31, 8'h24, 1'b0, 1'b0},
        '{16'h0FFF, 16'h0000, 5'd31, 8'h48, 1'b0, 1'b0},
        '{16'h9070, 16'h0001, 5'd7,  8'h2A, 1'b0, 1'b0},
        '{16'h9080, 16'h0001, 5'd8,  8'h2A, 1'b0, 1'b0},
        '{16'h9481, 16'h0000, 5'd8,  8'hD6, 1'b0, 1'b0},
        '{16'h0C78, 16'h0000, 5'd7,  8'h00, 1'b1, 1'b1},
        '{16'hFFFF, 16'h0000, 5'd7,  8'h00, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] w);
        while (!instr_ready) @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = 16'h0000;
    endtask

    task automatic settle();
        while (!instr_ready || busy) @(negedge clk);
    endtask

    task automatic peek_rf(input logic [4:0] idx, output logic [7:0] v);
        rf_rd_idx = idx;
        #1;
        v = rf_rd_data;
    endtask

    task automatic peek_io(input logic [5:0] idx, output logic [7:0] v);
        io_rd_idx = idx;
        #1;
        v = io_rd_data;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        peek_rf(5'd1, v);   chk("R1 rf1", {8'h0, v}, 16'h0000);
        peek_rf(5'd31, v);  chk("R1 rf31", {8'h0, v}, 16'h0000);
        peek_io(6'd0, v);   chk("R1 io0", {8'h0, v}, 16'h00FF);
        peek_io(6'd63, v);  chk("R1 io63", {8'h0, v}, 16'h00FF);
        chk("R1 flags/err", {13'h0, flag_z, flag_c, addr_err}, 16'h0000);
        chk("R1 ready/busy", {14'h0, instr_ready, busy}, 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: R2 R3 R4 R5 R6 R8 R11
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].w0);
            if (VEC[i].w0[15:9] == 7'b1001000 && VEC[i].w0[3:0] == 4'h0) begin
                issue(VEC[i].w1);
            end
            settle();
            peek_rf(VEC[i].rix, v);
            chk($sformatf("R2-R6 vec%0d value", i), {8'h0, v}, {8'h0, VEC[i].val});
            chk($sformatf("R8 vec%0d flags", i), {14'h0, flag_z, flag_c},
                {14'h0, VEC[i].z, VEC[i].c});
        end

        // R11: unknown word accepted in one cycle, busy stays low
        issue(16'hFFFF);
        chk("R11 busy after nop", {14'h0, instr_ready, busy}, 16'h0002);

        // R10: bit clear in I/O, others untouched; flags unchanged (R8)
        issue(16'h982A);
        peek_io(6'd5, v);  chk("R10 io5 bit2", {8'h0, v}, 16'h00FB);
        peek_io(6'd4, v);  chk("R10 io4 untouched", {8'h0, v}, 16'h00FF);
        chk("R8 flags after bit clear", {14'h0, flag_z, flag_c}, 16'h0003);
        issue(16'h98FF);
        peek_io(6'd31, v); chk("R10 io31 bit7", {8'h0, v}, 16'h007F);
        peek_io(6'd32, v); chk("R10 io32 unreachable", {8'h0, v}, 16'h00FF);

        // R7 timing and R12 address word that looks like a negate of r1
        issue(16'h90A0);
        chk("R7 addr phase", {14'h0, instr_ready, busy}, 16'h0003);
        issue(16'h9411);
        chk("R7 load cycle", {14'h0, instr_ready, busy}, 16'h0001);
        settle();
        peek_rf(5'd10, v); chk("R9 oob value", {8'h0, v}, 16'h0000);
        chk("R9 err set", {15'h0, addr_err}, 16'h0001);
        peek_rf(5'd1, v);  chk("R12 r1 untouched", {8'h0, v}, 16'h00F3);

        // R9: sticky across in-range loads, R6 boundary addresses
        issue(16'h90B0); issue(16'h0002); settle();
        peek_rf(5'd11, v); chk("R6 load addr2", {8'h0, v}, 16'h004F);
        chk("R9 err sticky", {15'h0, addr_err}, 16'h0001);
        issue(16'h90C0); issue(16'h001F); settle();
        peek_rf(5'd12, v); chk("R6 last address", {8'h0, v}, 16'h0080);
        issue(16'h90C0);
        repeat (3) @(negedge clk);
        chk("R7 wait holds", {14'h0, instr_ready, busy}, 16'h0003);
        issue(16'h0020); settle();
        peek_rf(5'd12, v); chk("R9 first oob address", {8'h0, v}, 16'h0000);
        chk("R8 flags after loads", {14'h0, flag_z, flag_c}, 16'h0003);

        finish_run();
    end
endmodule